// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps a 64-bit time value in nanoseconds. The value advances by a fixed 8 ns on every clock cycle. A drift corrector trims the effective rate: once per programmed interval, the step for a single cycle is made larger or smaller by a chosen number of nanoseconds, from 1 to 7. The base increment itself never changes.

Software reaches the block through a simple register port. Writes complete in one cycle. A read returns its data on `rd_data` one cycle after `rd_en`. Through this port, software can:
- pause and resume the counter;
- preset the counter while it is paused;
- program the drift correction under a reset handshake;
- read the time as two coherent 32-bit halves.

The current time is also driven directly on `time_ns` for neighbouring logic.

Register addresses: 0 load low word, 1 load high word, 2 run control, 3 drift configuration, 4 drift reset, 5 time low word, 6 time high word.

Top module: `tsc_drift_clock`

## Requirements
- R1: After reset, `time_ns` is 0, the counter is running, the drift configuration reads 0 and the drift-reset register reads 0.
- R2: While running with drift correction inactive, `time_ns` grows by exactly 8 every clock cycle.
- R3: Writing 2 to address 2 pauses the counter and writing 4 resumes it. Any other value written there leaves the run state unchanged. While paused, the time stays frozen.
- R4: While paused, a write to address 0 replaces bits 31:0 of the time and a write to address 1 replaces bits 63:32. Counting continues from that value on resume. Load writes made while running are ignored.
- R5: A read of address 5 returns time bits 31:0 and captures bits 63:32 at the same instant. A following read of address 6 returns the captured half, even if a carry into the upper half happened in between.
- R6: Bit 0 of address 4 is the drift reset. Reading address 4 returns 1 in bit 0 while the reset is held and 0 otherwise.
- R7: A write to address 3 is accepted only while the drift reset is held. Otherwise it is ignored and the previous configuration, readable at address 3, stays in effect.
- R8: The configuration word holds the period P in bits 27:0, the magnitude M in bits 30:28 and the direction D in bit 31. In every (2P+1)-th running cycle, which is P×16+8 ns, the step is 8+M when D=1 and 8−M when D=0.
- R9: A magnitude of 0 or a period of 0xFFFFFFF disables correction, and the step stays 8.
- R10: A period field of 0 acts as a period of 1, so the correction occurs every 3 running cycles.
- R11: Releasing the drift reset restarts the interval count at zero. The interval count advances only in running cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
The bench targets four corner cases:
- **Low-word carry between the two halves of a readout.** A design without the captured upper half returns an upper word that is one too large.
- **Period edges 0, 1 and 0xFFFFFFF.** An off-by-one in the interval compare, a missing clamp or a missing idle decode shows up as a wrong accumulated correction over many cycles.
- **Configuration writes while the drift reset is released.** A design that accepts them reads back the new word.
- **Load writes during running and unknown control values.** A design that wrongly accepts either shows a time that differs from 8 ns per running cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_LOAD_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LOAD_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DCFG    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DRST    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_TIME_LO = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_TIME_HI = 3'd6;
  localparam logic [31:0] CMD_PAUSE  = 32'd2;
  localparam logic [31:0] CMD_RESUME = 32'd4;
endpackage

// File: rtl/tsc_regif.sv
module tsc_regif
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TIME_W-1:0] time_ns,
  input  logic [CFG_W-1:0]  cfg,
  output logic              run,
  output logic              hold,
  output logic              load_lo_we,
  output logic              load_hi_we,
  output logic              cfg_we,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = TIME_W - DATA_W;

  logic              run_q, run_d;
  logic              hold_q, hold_d;
  logic [HI_W-1:0]   shadow_q, shadow_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              shadow_en, rdata_en;

  assign load_lo_we = wr_en && (wr_addr == ADR_LOAD_LO);
  assign load_hi_we = wr_en && (wr_addr == ADR_LOAD_HI);
  assign cfg_we     = wr_en && (wr_addr == ADR_DCFG);

  always_comb begin
    run_d  = run_q;
    hold_d = hold_q;
    if (wr_en && wr_addr == ADR_CTRL) begin
      if (wr_data == DATA_W'(CMD_PAUSE))       run_d = 1'b0;
      else if (wr_data == DATA_W'(CMD_RESUME)) run_d = 1'b1;
    end
    if (wr_en && wr_addr == ADR_DRST) hold_d = wr_data[0];
  end

  assign shadow_en = rd_en && (rd_addr == ADR_TIME_LO);
  assign shadow_d  = time_ns[TIME_W-1:DATA_W];
  assign rdata_en  = rd_en;

  always_comb begin
    case (rd_addr)
      ADR_DCFG:    rdata_d = DATA_W'(cfg);
      ADR_DRST:    rdata_d = DATA_W'(hold_q);
      ADR_TIME_LO: rdata_d = time_ns[DATA_W-1:0];
      ADR_TIME_HI: rdata_d = DATA_W'(shadow_q);
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b1;
      hold_q   <= 1'b0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
      if (shadow_en) shadow_q <= shadow_d;
      if (rdata_en)  rdata_q  <= rdata_d;
    end
  end

  assign run     = run_q;
  assign hold    = hold_q;
  assign rd_data = rdata_q;
endmodule

// File: rtl/tsc_drift.sv
module tsc_drift #(
  parameter int PER_W = 28,
  parameter int MAG_W = 3,
  parameter int CFG_W = PER_W + MAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hold,
  input  logic             run,
  output logic [CFG_W-1:0] cfg,
  output logic             fire,
  output logic             dir,
  output logic [MAG_W-1:0] mag
);
  localparam int TMR_W = PER_W + 1;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [PER_W-1:0] period, per_eff;
  logic [TMR_W-1:0] limit;
  logic             active;

  assign period  = cfg_q[PER_W-1:0];
  assign mag     = cfg_q[PER_W +: MAG_W];
  assign dir     = cfg_q[CFG_W-1];
  assign per_eff = (period == '0) ? PER_W'(1) : period;
  assign limit   = {per_eff, 1'b0};
  assign active  = (mag != '0) && (period != '1);
  assign fire    = active && run && !hold && (tmr_q == limit);

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we && hold) cfg_d = cfg_wdata;
  end

  always_comb begin
    tmr_d = tmr_q;
    if (hold)                tmr_d = '0;
    else if (run && active)  tmr_d = fire ? '0 : tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tmr_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      tmr_q <= tmr_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int TIME_W = 64,
  parameter int DATA_W = 32,
  parameter int INC    = 8,
  parameter int MAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_lo_we,
  input  logic              load_hi_we,
  input  logic [DATA_W-1:0] load_data,
  input  logic              adj_fire,
  input  logic              adj_dir,
  input  logic [MAG_W-1:0]  adj_mag,
  output logic [TIME_W-1:0] time_ns
);
  localparam int HI_W = TIME_W - DATA_W;

  logic [TIME_W-1:0] cnt_q, cnt_d, step;

  always_comb begin
    step = TIME_W'(INC);
    if (adj_fire) begin
      if (adj_dir) step = TIME_W'(INC) + TIME_W'(adj_mag);
      else         step = TIME_W'(INC) - TIME_W'(adj_mag);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      cnt_d = cnt_q + step;
    end else begin
      if (load_lo_we) cnt_d[DATA_W-1:0] = load_data;
      if (load_hi_we) cnt_d[TIME_W-1:DATA_W] = load_data[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign time_ns = cnt_q;
endmodule

// File: rtl/tsc_drift_clock.sv
module tsc_drift_clock
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64,
  parameter int INC    = 8,
  parameter int PER_W  = 28,
  parameter int MAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic [63:0]       time_ns
);
  localparam int CFG_W = PER_W + MAG_W + 1;

  logic [1:0]       sync_q;
  logic             srst_n;
  logic             run, drift_hold, load_lo_we, load_hi_we, cfg_we;
  logic             fire, dir;
  logic [MAG_W-1:0] mag;
  logic [CFG_W-1:0] drift_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  tsc_regif #(.DATA_W(DATA_W), .TIME_W(TIME_W), .CFG_W(CFG_W)) u_regif (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .time_ns(time_ns),
    .cfg(drift_cfg), .run(run), .hold(drift_hold), .load_lo_we(load_lo_we),
    .load_hi_we(load_hi_we), .cfg_we(cfg_we), .rd_data(rd_data)
  );

  tsc_drift #(.PER_W(PER_W), .MAG_W(MAG_W), .CFG_W(CFG_W)) u_drift (
    .clk(clk), .rst_n(srst_n), .cfg_we(cfg_we), .cfg_wdata(wr_data[CFG_W-1:0]),
    .hold(drift_hold), .run(run), .cfg(drift_cfg), .fire(fire), .dir(dir),
    .mag(mag)
  );

  tsc_counter #(.TIME_W(TIME_W), .DATA_W(DATA_W), .INC(INC), .MAG_W(MAG_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .run(run), .load_lo_we(load_lo_we),
    .load_hi_we(load_hi_we), .load_data(wr_data), .adj_fire(fire),
    .adj_dir(dir), .adj_mag(mag), .time_ns(time_ns)
  );
endmodule

// File: rtl/tsc_drift_clock_chk.sv
module tsc_drift_clock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        rd_en,
  input logic [2:0]  rd_addr,
  input logic [31:0] rd_data,
  input logic [63:0] time_ns,
  input logic        run,
  input logic        hold,
  input logic [31:0] cfg
);
  assert_pause_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1))) |=> $stable(time_ns));

  assert_step_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ((time_ns - $past(time_ns)) >= 64'd1 && (time_ns - $past(time_ns)) <= 64'd15));

  assert_plain_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg[30:28] == 3'd0) |=> (time_ns == $past(time_ns) + 64'd8));

  assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3 && !hold) |=> $stable(cfg));

  assert_low_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd5) |=> (rd_data == $past(time_ns[31:0])));

  assert_hold_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd4) |=> (rd_data == {31'd0, $past(hold)}));
endmodule

bind tsc_drift_clock tsc_drift_clock_chk u_chk (
  .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .time_ns(time_ns),
  .run(run), .hold(drift_hold), .cfg(drift_cfg)
);

// File: tb/tsc_drift_clock_test.sv
`timescale 1ns/1ps
module tsc_drift_clock_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [63:0] time_ns;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  tsc_drift_clock uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .time_ns(time_ns)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd5, lo);
    rd(3'd6, hi);
    t = {hi, lo};
  endtask

  function automatic logic [63:0] model(logic [63:0] v, int n, int p, int m, bit d);
    longint pe = (p == 0) ? 1 : p;
    longint fires = (m != 0 && p != 32'h0FFFFFFF) ? n / (2 * pe + 1) : 0;
    logic [63:0] r = v + 64'(8 * n);
    if (d) r = r + 64'(fires * m);
    else   r = r - 64'(fires * m);
    return r;
  endfunction

  // pause, program drift, preset, run n cycles, pause, return readout
  task automatic run_case(logic [63:0] v, int n, int p, int m, bit d,
                          output logic [63:0] t);
    wr(3'd2, 32'd2);
    wr(3'd4, 32'd1);
    wr(3'd3, {d, 3'(m), 28'(p)});
    wr(3'd4, 32'd0);
    wr(3'd0, v[31:0]);
    wr(3'd1, v[63:32]);
    wr(3'd2, 32'd4);
    repeat (n - 1) @(negedge clk);
    wr(3'd2, 32'd2);
    read_time(t);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, t0;
    void'($urandom(32'h1234ABCD));
    wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 time in reset", time_ns, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2: running, plain 8 ns step
    t0 = time_ns;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check("R2 step", time_ns, t0 + 64'(8 * i));
    end
    rd(3'd3, d); check("R1 cfg reset", {32'd0, d}, 64'd0);
    rd(3'd4, d); check("R1 drst reset", {32'd0, d}, 64'd0);

    // R6: drift reset readback
    wr(3'd4, 32'd1);
    rd(3'd4, d); check("R6 held", {32'd0, d}, 64'd1);
    wr(3'd3, 32'hA000_0005);
    wr(3'd4, 32'd0);
    rd(3'd4, d); check("R6 released", {32'd0, d}, 64'd0);
    // R7: write while released is ignored
    wr(3'd3, 32'h1234_5678);
    rd(3'd3, d); check("R7 cfg ignored", {32'd0, d}, 64'hA000_0005);

    // R3: unknown command keeps pause
    wr(3'd2, 32'd2);
    read_time(t0);
    wr(3'd2, 32'd7);
    repeat (5) @(negedge clk);
    read_time(t);
    check("R3 paused stays", t, t0);

    // R4: load ignored while running
    wr(3'd4, 32'd1); wr(3'd3, 32'd0); wr(3'd4, 32'd0);
    wr(3'd0, 32'h0000_1000); wr(3'd1, 32'h0000_0002);
    wr(3'd2, 32'd4);
    wr(3'd0, 32'hDEAD_BEEF);
    repeat (8) @(negedge clk);
    wr(3'd2, 32'd2);
    read_time(t);
    check("R4 run load ignored", t, 64'h0000_0002_0000_1000 + 64'd80);

    // R5: carry between halves of a read
    wr(3'd0, 32'hFFFF_FFF8); wr(3'd1, 32'h0000_0001);
    wr(3'd2, 32'd4);
    read_time(t);
    check("R5 coherent read", t, 64'h0000_0001_FFFF_FFF8);
    wr(3'd2, 32'd2);

    // R8 add and subtract, R10 period 0, R9 idle period / zero magnitude
    run_case(64'd1000, 30, 0, 3, 1'b1, t);
    check("R10 period zero", t, model(64'd1000, 30, 0, 3, 1'b1));
    run_case(64'd5000, 31, 1, 7, 1'b0, t);
    check("R8 subtract P1", t, model(64'd5000, 31, 1, 7, 1'b0));
    run_case(64'd0, 100, 32'h0FFFFFFF, 7, 1'b1, t);
    check("R9 idle period", t, 64'd800);
    run_case(64'd77, 50, 2, 0, 1'b1, t);
    check("R9 zero magnitude", t, 64'd477);
    run_case(64'hFFFF_FFFF_FFFF_FF00, 40, 4, 5, 1'b1, t);
    check("R8 wrap add", t, model(64'hFFFF_FFFF_FFFF_FF00, 40, 4, 5, 1'b1));
    // R11: release restarts interval; 4 cycles with P=2 gives no fire
    run_case(64'd0, 4, 2, 7, 1'b1, t);
    check("R11 fresh interval", t, 64'd32);
    run_case(64'd0, 5, 2, 7, 1'b1, t);
    check("R11 first fire", t, 64'd47);

    for (int k = 0; k < 40; k++) begin
      logic [63:0] v = {$urandom, $urandom};
      int n = $urandom_range(1, 150);
      int p = $urandom_range(0, 12);
      int m = $urandom_range(0, 7);
      bit dd = 1'($urandom);
      run_case(v, n, p, m, dd, t);
      check("R8 random", t, model(v, n, p, m, dd));
      rd(3'd3, d);
      check("R7 cfg readback", {32'd0, d}, {32'd0, dd, 3'(m), 28'(p)});
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule